// File: doc/BRIEF.md
# Single-Step Trace Trap Controller

This block sits beside the completion stage of an in-order processor and produces a trace trap after each instruction that finishes while single-step tracing is switched on. On every retirement strobe it looks at four things: the trace-enable field, whether the instruction faulted, whether it was a return-from-interrupt, and the instruction's class. When all of them allow a trap, it latches the address the program would have continued at, together with two status bits. One bit records load-like behaviour and the other store-like behaviour. Some cache-maintenance operations are folded into those two groups.

A latched trace trap is presented on the interrupt request with the trace vector 0xD00. It outranks any asynchronous request, including one that arrives in the same cycle as the traced completion. It also holds off the issue of the next instruction until the interrupt logic acknowledges it. The acknowledge produces a one-cycle pulse telling the control-register logic to clear trace enable, so that the handler itself runs untraced. When no trace trap is pending, an asynchronous request passes straight through with its own vector.

Top module: `step_trap_ctrl`

## Requirements
- R1: A completion (`done_valid`=1) with nonzero `trace_en`, `done_fault`=0 and a class other than 10 raises `irq_req`=1, `irq_is_trace`=1 and `irq_vector`=0xD00 from the next cycle on.
- R2: A completion while `trace_en` is zero raises no trace trap.
- R3: A completion of class 10 (return from interrupt) raises no trace trap.
- R4: A completion with `done_fault`=1 raises no trace trap.
- R5: When a trace trap is raised, `save_pc` holds the `done_next_pc` value of the traced completion.
- R6: Class codes 1 (load), 3 (icache invalidate), 4 (icache touch), 5 (dcache touch), 6 (dcache store-back) and 7 (dcache flush) set `save_load`. Codes 2 (store), 8 (dcache touch-for-store) and 9 (dcache zero) set `save_store`. Codes 0 and 11 to 15 set neither bit. The two bits are never both set.
- R7: A pending trace trap, or a traced completion in its own cycle, masks `async_req`. When neither is present, `async_req` drives `irq_req`=1 with `irq_vector`=0x500 in the same cycle.
- R8: `issue_hold` is 1 in the cycle of a traced completion and in every cycle a trace trap is pending.
- R9: A pending trace trap stays asserted until `irq_ack`. While it is pending, the saved address and status bits do not change, and further completions are ignored.
- R10: `irq_ack` while a trace trap is pending gives `trace_en_clr`=1 in that cycle, and the trap is gone in the next cycle.
- R11: After reset, `irq_req`, `irq_is_trace`, `issue_hold`, `save_pc`, `save_load`, `save_store` and `trace_en_clr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_en | input | TE_W | Single-step trace-enable field; any nonzero value enables tracing |
| done_valid | input | 1 | Instruction completion strobe |
| done_class | input | 4 | Class code of the completing instruction |
| done_fault | input | 1 | Completing instruction raised its own exception |
| done_next_pc | input | ADDR_W | Address of the instruction that follows the completing one |
| async_req | input | 1 | Asynchronous interrupt request |
| irq_ack | input | 1 | Interrupt logic has taken the presented interrupt |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | VEC_W | Vector of the presented interrupt |
| irq_is_trace | output | 1 | Presented interrupt is the trace trap |
| save_pc | output | ADDR_W | Saved resume address |
| save_load | output | 1 | Traced instruction acted as a load |
| save_store | output | 1 | Traced instruction acted as a store |
| issue_hold | output | 1 | Block issue of the next instruction |
| trace_en_clr | output | 1 | One-cycle pulse to clear trace enable |

## Verification
The bench builds the block with a 32-bit address and a two-bit trace-enable field, and keeps the default vectors. With a two-bit field, the enable values 1, 2 and 3 can each be shown to count as "on". The narrower address keeps the vector table compact while still showing that the whole saved address is captured. All eleven class codes with a named meaning are driven, plus one unassigned code. The table includes completions that coincide with an asynchronous request, as well as completions and acknowledges that arrive while a trap is already pending.

// File: rtl/step_trap_pkg.sv
package step_trap_pkg;

  localparam int CLASS_W = 4;

  typedef enum logic [CLASS_W-1:0] {
    CL_OTHER      = 4'd0,
    CL_LOAD       = 4'd1,
    CL_STORE      = 4'd2,
    CL_IC_INVAL   = 4'd3,
    CL_IC_TOUCH   = 4'd4,
    CL_DC_TOUCH   = 4'd5,
    CL_DC_WRBACK  = 4'd6,
    CL_DC_FLUSH   = 4'd7,
    CL_DC_TOUCHST = 4'd8,
    CL_DC_ZERO    = 4'd9,
    CL_INT_RETURN = 4'd10
  } done_class_e;

  // Instructions reported to the handler as reads of memory.
  function automatic logic acts_as_load(input logic [CLASS_W-1:0] cls);
    case (cls)
      CL_LOAD, CL_IC_INVAL, CL_IC_TOUCH,
      CL_DC_TOUCH, CL_DC_WRBACK, CL_DC_FLUSH: acts_as_load = 1'b1;
      default:                                acts_as_load = 1'b0;
    endcase
  endfunction

  // Instructions reported to the handler as writes of memory.
  function automatic logic acts_as_store(input logic [CLASS_W-1:0] cls);
    case (cls)
      CL_STORE, CL_DC_TOUCHST, CL_DC_ZERO: acts_as_store = 1'b1;
      default:                             acts_as_store = 1'b0;
    endcase
  endfunction

  function automatic logic is_int_return(input logic [CLASS_W-1:0] cls);
    is_int_return = (cls == CL_INT_RETURN);
  endfunction

endpackage

// File: rtl/step_trap_classify.sv
module step_trap_classify
  import step_trap_pkg::*;
(
  input  logic [CLASS_W-1:0] done_class,
  output logic               load_like,
  output logic               store_like,
  output logic               int_return
);

  always_comb begin
    load_like  = acts_as_load(done_class);
    store_like = acts_as_store(done_class);
    int_return = is_int_return(done_class);
  end

endmodule

// File: rtl/step_trap_capture.sv
module step_trap_capture #(
  parameter int ADDR_W = 64,
  parameter int TE_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TE_W-1:0]   trace_en,
  input  logic              done_valid,
  input  logic              done_fault,
  input  logic              int_return,
  input  logic              load_like,
  input  logic              store_like,
  input  logic [ADDR_W-1:0] done_next_pc,
  input  logic              irq_ack,
  output logic              trace_hit,
  output logic              trace_pend,
  output logic              trace_take,
  output logic [ADDR_W-1:0] save_pc,
  output logic              save_load,
  output logic              save_store
);

  logic trace_on;

  assign trace_on   = |trace_en;
  // A completion is only considered while no trap is waiting: the core is
  // held, so anything arriving then is not a real retirement.
  assign trace_hit  = done_valid & trace_on & ~done_fault & ~int_return & ~trace_pend;
  assign trace_take = trace_pend & irq_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trace_pend <= 1'b0;
      save_pc    <= '0;
      save_load  <= 1'b0;
      save_store <= 1'b0;
    end else if (trace_hit) begin
      trace_pend <= 1'b1;
      save_pc    <= done_next_pc;
      save_load  <= load_like;
      save_store <= store_like;
    end else if (trace_take) begin
      trace_pend <= 1'b0;
    end
  end

endmodule

// File: rtl/step_trap_arb.sv
module step_trap_arb #(
  parameter int               VEC_W     = 12,
  parameter logic [VEC_W-1:0] TRACE_VEC = 12'hD00,
  parameter logic [VEC_W-1:0] ASYNC_VEC = 12'h500
) (
  input  logic             trace_pend,
  input  logic             trace_hit,
  input  logic             async_req,
  output logic             irq_req,
  output logic             irq_is_trace,
  output logic [VEC_W-1:0] irq_vector,
  output logic             issue_hold
);

  logic async_win;

  assign async_win = async_req & ~trace_pend & ~trace_hit;

  always_comb begin
    irq_req      = trace_pend | async_win;
    irq_is_trace = trace_pend;
    issue_hold   = trace_pend | trace_hit;
    if (trace_pend)     irq_vector = TRACE_VEC;
    else if (async_win) irq_vector = ASYNC_VEC;
    else                irq_vector = '0;
  end

endmodule

// File: rtl/step_trap_ctrl.sv
module step_trap_ctrl
  import step_trap_pkg::*;
#(
  parameter int               ADDR_W    = 64,
  parameter int               TE_W      = 2,
  parameter int               VEC_W     = 12,
  parameter logic [VEC_W-1:0] TRACE_VEC = 12'hD00,
  parameter logic [VEC_W-1:0] ASYNC_VEC = 12'h500
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TE_W-1:0]    trace_en,
  input  logic               done_valid,
  input  logic [CLASS_W-1:0] done_class,
  input  logic               done_fault,
  input  logic [ADDR_W-1:0]  done_next_pc,
  input  logic               async_req,
  input  logic               irq_ack,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vector,
  output logic               irq_is_trace,
  output logic [ADDR_W-1:0]  save_pc,
  output logic               save_load,
  output logic               save_store,
  output logic               issue_hold,
  output logic               trace_en_clr
);

  logic load_like, store_like, int_return;
  logic trace_hit, trace_pend, trace_take;

  step_trap_classify u_classify (
    .done_class (done_class),
    .load_like  (load_like),
    .store_like (store_like),
    .int_return (int_return)
  );

  step_trap_capture #(.ADDR_W(ADDR_W), .TE_W(TE_W)) u_capture (
    .clk          (clk),
    .rst_n        (rst_n),
    .trace_en     (trace_en),
    .done_valid   (done_valid),
    .done_fault   (done_fault),
    .int_return   (int_return),
    .load_like    (load_like),
    .store_like   (store_like),
    .done_next_pc (done_next_pc),
    .irq_ack      (irq_ack),
    .trace_hit    (trace_hit),
    .trace_pend   (trace_pend),
    .trace_take   (trace_take),
    .save_pc      (save_pc),
    .save_load    (save_load),
    .save_store   (save_store)
  );

  step_trap_arb #(.VEC_W(VEC_W), .TRACE_VEC(TRACE_VEC), .ASYNC_VEC(ASYNC_VEC)) u_arb (
    .trace_pend   (trace_pend),
    .trace_hit    (trace_hit),
    .async_req    (async_req),
    .irq_req      (irq_req),
    .irq_is_trace (irq_is_trace),
    .irq_vector   (irq_vector),
    .issue_hold   (issue_hold)
  );

  assign trace_en_clr = trace_take;

endmodule

// File: rtl/step_trap_ctrl_chk.sv
module step_trap_ctrl_chk #(
  parameter int               ADDR_W    = 64,
  parameter int               TE_W      = 2,
  parameter int               VEC_W     = 12,
  parameter logic [VEC_W-1:0] TRACE_VEC = 12'hD00
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TE_W-1:0]   trace_en,
  input logic              done_valid,
  input logic [3:0]        done_class,
  input logic              done_fault,
  input logic [ADDR_W-1:0] done_next_pc,
  input logic              irq_ack,
  input logic              irq_req,
  input logic [VEC_W-1:0]  irq_vector,
  input logic              irq_is_trace,
  input logic [ADDR_W-1:0] save_pc,
  input logic              save_load,
  input logic              save_store,
  input logic              issue_hold,
  input logic              trace_en_clr,
  input logic              trace_hit,
  input logic              trace_pend
);

  assert_trace_raise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && trace_en != '0 && !done_fault && done_class != 4'd10 && !trace_pend)
      |=> (irq_req && irq_is_trace && irq_vector == TRACE_VEC));

  assert_no_trace_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && trace_en == '0 && !trace_pend) |=> !irq_is_trace);

  assert_no_trace_on_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_class == 4'd10 && !trace_pend) |=> !irq_is_trace);

  assert_no_trace_on_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_fault && !trace_pend) |=> !irq_is_trace);

  assert_saved_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trace_hit |=> (save_pc == $past(done_next_pc)));

  assert_ld_st_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({save_load, save_store}));

  assert_trace_vector_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trace_pend |-> (irq_req && irq_vector == TRACE_VEC));

  assert_hold_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_pend || trace_hit) |-> issue_hold);

  assert_pending_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_pend && !irq_ack)
      |=> (trace_pend && $stable(save_pc) && $stable(save_load) && $stable(save_store)));

  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_pend && irq_ack) |=> !irq_is_trace);

  assert_clear_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trace_en_clr |-> (irq_is_trace && irq_ack));

endmodule

bind step_trap_ctrl step_trap_ctrl_chk #(
  .ADDR_W(ADDR_W), .TE_W(TE_W), .VEC_W(VEC_W), .TRACE_VEC(TRACE_VEC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .trace_en     (trace_en),
  .done_valid   (done_valid),
  .done_class   (done_class),
  .done_fault   (done_fault),
  .done_next_pc (done_next_pc),
  .irq_ack      (irq_ack),
  .irq_req      (irq_req),
  .irq_vector   (irq_vector),
  .irq_is_trace (irq_is_trace),
  .save_pc      (save_pc),
  .save_load    (save_load),
  .save_store   (save_store),
  .issue_hold   (issue_hold),
  .trace_en_clr (trace_en_clr),
  .trace_hit    (trace_hit),
  .trace_pend   (trace_pend)
);

// File: tb/step_trap_ctrl_tb_top.sv
`timescale 1ns/1ps
module step_trap_ctrl_tb_top;

  localparam int AW = 32;
  localparam int TW = 2;
  localparam int VW = 12;
  localparam logic [VW-1:0] TV = 12'hD00;
  localparam logic [VW-1:0] AV = 12'h500;

  typedef struct packed {
    logic [TW-1:0] te;
    logic [3:0]    cls;
    logic          fault;
    logic [AW-1:0] pc;
    logic          asy;
    logic          exp_tr;
    logic          exp_ld;
    logic          exp_st;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 4'd1,  1'b0, 32'h0000_1004, 1'b0, 1'b1, 1'b1, 1'b0}, // R1 R6 load
    '{2'd2, 4'd2,  1'b0, 32'h0000_2008, 1'b0, 1'b1, 1'b0, 1'b1}, // R6 store
    '{2'd3, 4'd3,  1'b0, 32'hFFFF_FFFC, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 icache invalidate
    '{2'd1, 4'd4,  1'b0, 32'h8000_0000, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 icache touch
    '{2'd1, 4'd5,  1'b0, 32'h0000_0010, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 dcache touch
    '{2'd1, 4'd6,  1'b0, 32'h0000_0014, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 dcache store-back
    '{2'd1, 4'd7,  1'b0, 32'h0000_0018, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 dcache flush
    '{2'd1, 4'd8,  1'b0, 32'h0000_001C, 1'b0, 1'b1, 1'b0, 1'b1}, // R6 touch-for-store
    '{2'd1, 4'd9,  1'b0, 32'h0000_0020, 1'b0, 1'b1, 1'b0, 1'b1}, // R6 dcache zero
    '{2'd1, 4'd0,  1'b0, 32'h1234_5678, 1'b0, 1'b1, 1'b0, 1'b0}, // R6 plain
    '{2'd1, 4'd10, 1'b0, 32'h0000_0700, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 return
    '{2'd0, 4'd1,  1'b0, 32'h0000_0800, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 off
    '{2'd1, 4'd2,  1'b1, 32'h0000_0900, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 fault
    '{2'd3, 4'd1,  1'b0, 32'hA5A5_5A5C, 1'b1, 1'b1, 1'b1, 1'b0}, // R7 trace beats async
    '{2'd0, 4'd0,  1'b0, 32'h0000_0A00, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 async passes
    '{2'd1, 4'd10, 1'b0, 32'h0000_0B00, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 R7 return + async
    '{2'd2, 4'd12, 1'b0, 32'h0000_0C00, 1'b0, 1'b1, 1'b0, 1'b0}  // R6 unassigned code
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] trace_en = '0;
  logic          done_valid = 1'b0;
  logic [3:0]    done_class = '0;
  logic          done_fault = 1'b0;
  logic [AW-1:0] done_next_pc = '0;
  logic          async_req = 1'b0;
  logic          irq_ack = 1'b0;
  logic          irq_req, irq_is_trace, save_load, save_store, issue_hold, trace_en_clr;
  logic [VW-1:0] irq_vector;
  logic [AW-1:0] save_pc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  step_trap_ctrl #(.ADDR_W(AW), .TE_W(TW), .VEC_W(VW), .TRACE_VEC(TV), .ASYNC_VEC(AV)) dut_i (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .done_valid(done_valid),
    .done_class(done_class), .done_fault(done_fault), .done_next_pc(done_next_pc),
    .async_req(async_req), .irq_ack(irq_ack), .irq_req(irq_req), .irq_vector(irq_vector),
    .irq_is_trace(irq_is_trace), .save_pc(save_pc), .save_load(save_load),
    .save_store(save_store), .issue_hold(issue_hold), .trace_en_clr(trace_en_clr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 irq_req", irq_req, 0);
    chk("R11 hold", issue_hold, 0);
    chk("R11 save_pc", save_pc, 0);
    chk("R11 ld/st", {save_load, save_store}, 0);
    chk("R11 clr", trace_en_clr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      trace_en     = VECS[i].te;
      done_class   = VECS[i].cls;
      done_fault   = VECS[i].fault;
      done_next_pc = VECS[i].pc;
      async_req    = VECS[i].asy;
      done_valid   = 1'b1;
      #1;
      // completion cycle: R7 masking and R8 hold
      chk("R8 hold in hit cycle", issue_hold, VECS[i].exp_tr);
      chk("R7 req in hit cycle", irq_req, VECS[i].asy & ~VECS[i].exp_tr);
      @(negedge clk);
      done_valid = 1'b0;
      chk("R1 R2 R3 R4 trace raised", irq_is_trace, VECS[i].exp_tr);
      if (VECS[i].exp_tr) begin
        chk("R1 vector", irq_vector, TV);
        chk("R1 req", irq_req, 1);
        chk("R5 save_pc", save_pc, VECS[i].pc);
        chk("R6 save_load", save_load, VECS[i].exp_ld);
        chk("R6 save_store", save_store, VECS[i].exp_st);
        chk("R8 hold pending", issue_hold, 1);
        // R9 completion while pending is ignored
        done_valid = 1'b1;
        done_class = 4'd2;
        done_next_pc = ~VECS[i].pc;
        @(negedge clk);
        done_valid = 1'b0;
        chk("R9 still pending", irq_is_trace, 1);
        chk("R9 pc stable", save_pc, VECS[i].pc);
        chk("R9 status stable", {save_load, save_store}, {VECS[i].exp_ld, VECS[i].exp_st});
        irq_ack = 1'b1;
        #1;
        chk("R10 clear pulse", trace_en_clr, 1);
        @(negedge clk);
        irq_ack = 1'b0;
        chk("R10 trap gone", irq_is_trace, 0);
        chk("R10 clr low", trace_en_clr, 0);
        chk("R7 async after trap", irq_req, VECS[i].asy);
      end else begin
        chk("R7 async req", irq_req, VECS[i].asy);
        chk("R7 async vector", irq_vector, VECS[i].asy ? 64'(AV) : 64'd0);
        chk("R8 no hold", issue_hold, 0);
        // R10 ack without a trace trap gives no clear pulse
        irq_ack = 1'b1;
        #1;
        chk("R10 no pulse", trace_en_clr, 0);
        @(negedge clk);
        irq_ack = 1'b0;
      end
      async_req = 1'b0;
      @(negedge clk);
    end

    // R9 trap held for several cycles without acknowledge
    trace_en = 2'd1; done_class = 4'd9; done_fault = 1'b0;
    done_next_pc = 32'hCAFE_0000; done_valid = 1'b1;
    @(negedge clk);
    done_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 held long", irq_is_trace, 1);
    chk("R9 pc long", save_pc, 32'hCAFE_0000);
    chk("R6 zero store", save_store, 1);
    async_req = 1'b1;
    #1;
    chk("R7 async masked", irq_vector, TV);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R7 async after ack", irq_vector, AV);
    async_req = 1'b0;

    // R11 reset mid-pending
    done_valid = 1'b1;
    @(negedge clk);
    done_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R11 reset clears trap", irq_req, 0);
    chk("R11 reset clears pc", save_pc, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule